// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Control

This block holds the data-hazard control for an in-order, five-stage pipeline (fetch, decode, execute, memory, write-back) built around a load/store register machine. It is purely combinational and sits beside the datapath. It sees register numbers and a few flags taken from the pipeline registers. It drives the two ALU operand multiplexers and the stage write enables. The datapath, register file and memories are outside it.

For each ALU operand of the instruction now in execute, the block compares the source register with the destinations of the two older instructions still in flight: the one in the memory stage, and the one in write-back. When both match, the younger of the two wins. Producers further away need no bypass, because their value has already reached the register file. Only read-after-write hazards get any logic. Writes happen in a single stage and in program order, so write-after-read and write-after-write cases cannot occur.

A load in execute cannot bypass its result to the instruction right behind it in decode. When that instruction needs the loaded register, the block holds fetch and decode for one cycle and injects a bubble into execute. A store in decode is an exception: it stalls only when the load writes the store's base-address register. When the load feeds only the store's data register, there is no stall, because that value is supplied later on. No data stream crosses the block's edge, so it has no valid/ready handshake, and every pin is a plain control or status signal.

Top module: `hazard_unit`

## Requirements
- R1: An operand select is 2'b10 (memory-stage result) when the memory-stage producer has its write enable set, its destination is not register 31, and its destination equals that operand's source in execute.
- R2: An operand select is 2'b01 (write-back value) when the write-back producer matches in the same sense and the memory-stage producer does not.
- R3: When both producers match the same operand, the select is 2'b10, so the younger instruction wins.
- R4: An operand select is 2'b00 (register file) when no producer matches. A producer whose write enable is low, or whose destination is register 31, never matches.
- R5: The select for operand A (source field `ex_src_a`) and the select for operand B (`ex_src_b`) are each decided only from their own source register.
- R6: When execute holds a load (load flag and write enable set, destination not 31) whose destination equals either source of a non-store in decode, the block stalls in that same cycle: `pc_we`=0, `ifid_we`=0, `idex_bubble`=1.
- R7: Without a load-use condition, `pc_we`=1, `ifid_we`=1 and `idex_bubble`=0. A non-load producer in execute never causes a stall.
- R8: When a store is in decode, `id_src_a` is its base register and `id_src_b` is its data register. The block stalls only when the load's destination equals the base register. A match on the data register alone gives no stall.
- R9: A load whose destination is register 31 never causes a stall.
- R10: `pc_we` and `ifid_we` are always equal, and `idex_bubble` is always their inverse.
- R11: Take a load followed by a dependent instruction. After the single stall cycle and the bubble, the dependent instruction reaches execute while the load is in write-back, and its operand select is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | 5 | First source register of the decode instruction (base register for a store) |
| id_src_b | input | 5 | Second source register of the decode instruction (data register for a store) |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_src_a | input | 5 | Operand A source register of the execute instruction |
| ex_src_b | input | 5 | Operand B source register of the execute instruction |
| ex_dst | input | 5 | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Destination register held in the memory-stage register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination register held in the write-back stage register |
| wb_wen | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | Operand A source select: 00 register file, 10 memory stage, 01 write-back |
| fwd_b | output | 2 | Operand B source select, same encoding |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode pipeline register write enable |
| idex_bubble | output | 1 | Zero the control fields being written into the execute register |

## Verification
The assertions assume that every input is stable, settled combinational data from the pipeline registers, and that a load flag is meaningful only when its write enable is set. The store flag in decode is taken to name base and data in fixed source positions. The bench draws register numbers from a small pool of low registers plus register 31, so matches, double matches and zero-register cases all occur often. It drives its inputs only between clock edges, so the outputs have settled before the assertions and the reference comparison see them. A directed sequence walks one load and its consumer through stall, bubble and write-back, the way a real pipeline would advance them.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // operand source selection; codes are decoded by the datapath muxes
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int REG_W    = 5,
  parameter int ZERO_REG = 31
) (
  input  logic             wen,
  input  logic [REG_W-1:0] dst,
  input  logic [REG_W-1:0] src,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_ID = REG_W'(ZERO_REG);

  // a producer counts only if it truly writes a real register
  assign hit = wen && (dst != ZERO_ID) && (dst == src);
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int ZERO_REG = 31
) (
  input  logic             [REG_W-1:0] src,
  input  logic                         mem_wen,
  input  logic             [REG_W-1:0] mem_dst,
  input  logic                         wb_wen,
  input  logic             [REG_W-1:0] wb_dst,
  output fwd_src_e                     sel
);
  logic mem_hit;
  logic wb_hit;

  hz_match #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_mem (
    .wen(mem_wen), .dst(mem_dst), .src(src), .hit(mem_hit)
  );
  hz_match #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_wb (
    .wen(wb_wen), .dst(wb_dst), .src(src), .hit(wb_hit)
  );

  // younger producer is examined first
  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_W    = 5,
  parameter int ZERO_REG = 31
) (
  input  logic             ex_is_load,
  input  logic             ex_wen,
  input  logic [REG_W-1:0] ex_dst,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_is_store,
  output logic             stall
);
  logic base_hit;
  logic data_hit;

  hz_match #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_base (
    .wen(ex_wen), .dst(ex_dst), .src(id_src_a), .hit(base_hit)
  );
  hz_match #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_data (
    .wen(ex_wen), .dst(ex_dst), .src(id_src_b), .hit(data_hit)
  );

  // a store's data operand is supplied later, so only its base needs the wait
  logic need_b;
  assign need_b = data_hit && !id_is_store;
  assign stall  = ex_is_load && (base_hit || need_b);
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
  import hz_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int ZERO_REG = 31
) (
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             id_is_store,
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             idex_bubble
);
  localparam int N_OPND = 2;

  logic     [REG_W-1:0] opnd_src [N_OPND];
  fwd_src_e             opnd_sel [N_OPND];
  logic                 hold;

  assign opnd_src[0] = ex_src_a;
  assign opnd_src[1] = ex_src_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    hz_fwd_pick #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_pick (
      .src    (opnd_src[g]),
      .mem_wen(mem_wen),
      .mem_dst(mem_dst),
      .wb_wen (wb_wen),
      .wb_dst (wb_dst),
      .sel    (opnd_sel[g])
    );
  end

  assign fwd_a = opnd_sel[0];
  assign fwd_b = opnd_sel[1];

  hz_load_use #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_lu (
    .ex_is_load (ex_is_load),
    .ex_wen     (ex_wen),
    .ex_dst     (ex_dst),
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .id_is_store(id_is_store),
    .stall      (hold)
  );

  // fetch and decode freeze while execute receives a bubble
  assign pc_we       = !hold;
  assign ifid_we     = !hold;
  assign idex_bubble = hold;
endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
  parameter int REG_W    = 5,
  parameter int ZERO_REG = 31
) (
  input logic [REG_W-1:0] id_src_a,
  input logic [REG_W-1:0] id_src_b,
  input logic             id_is_store,
  input logic [REG_W-1:0] ex_src_a,
  input logic [REG_W-1:0] ex_src_b,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_wen,
  input logic             ex_is_load,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wen,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_wen,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             pc_we,
  input logic             ifid_we,
  input logic             idex_bubble
);
  localparam logic [REG_W-1:0] Z = REG_W'(ZERO_REG);

  always_comb begin
    // R3
    if (mem_wen && wb_wen && mem_dst != Z && mem_dst == wb_dst && mem_dst == ex_src_a)
      young_wins_chk: assert (fwd_a == 2'b10) else $error("younger producer lost");
    // R4
    if (!wb_wen && (mem_dst == Z || !mem_wen))
      no_src_chk: assert (fwd_b == 2'b00) else $error("bypass from non-writer");
    // R10
    enables_agree_chk: assert (pc_we == ifid_we && idex_bubble == !pc_we)
      else $error("stall controls disagree");
    // R7
    if (!ex_is_load)
      only_load_chk: assert (!idex_bubble) else $error("stall without load");
    // R8
    if (id_is_store && id_src_a != ex_dst)
      store_data_chk: assert (pc_we) else $error("store data match stalled");
    // R9
    if (ex_dst == Z)
      zero_load_chk: assert (ifid_we) else $error("zero register stalled");
    // R6
    if (ex_is_load && ex_wen && ex_dst != Z && ex_dst == id_src_a)
      load_use_chk: assert (idex_bubble) else $error("missed load-use stall");
  end
endmodule

bind hazard_unit hazard_unit_chk #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_chk (
  .id_src_a(id_src_a), .id_src_b(id_src_b), .id_is_store(id_is_store),
  .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst),
  .ex_wen(ex_wen), .ex_is_load(ex_is_load),
  .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we), .ifid_we(ifid_we),
  .idex_bubble(idex_bubble)
);

// File: tb/sim_hazard_unit.sv
`timescale 1ns/1ps
module sim_hazard_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic [4:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
  logic       id_is_store, ex_wen, ex_is_load, mem_wen, wb_wen;
  logic [1:0] fwd_a, fwd_b;
  logic       pc_we, ifid_we, idex_bubble;

  int checks = 0;
  int errors = 0;

  hazard_unit u0 (
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_is_store(id_is_store),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst),
    .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_we(pc_we), .ifid_we(ifid_we),
    .idex_bubble(idex_bubble)
  );

  // reference: older producer first, younger overwrites
  function automatic int ref_sel(int src, int mw, int md, int ww, int wd);
    int r = 0;
    if (ww != 0 && wd != 31 && wd == src) r = 1;
    if (mw != 0 && md != 31 && md == src) r = 2;
    return r;
  endfunction

  function automatic int ref_stall(int ld, int w, int d, int a, int b, int st);
    if (ld == 0 || w == 0 || d == 31) return 0;
    if (d == a) return 1;
    if (st == 0 && d == b) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(int src);
    bit mh = mem_wen && mem_dst != 31 && int'(mem_dst) == src;
    bit wh = wb_wen && wb_dst != 31 && int'(wb_dst) == src;
    if (mh && wh) return "R3";
    if (mh) return "R1";
    if (wh) return "R2";
    return "R4";
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(string fa_tag, string st_tag);
    int e_st;
    chk(fa_tag, fwd_a, ref_sel(ex_src_a, mem_wen, mem_dst, wb_wen, wb_dst));
    chk(fa_tag, fwd_b, ref_sel(ex_src_b, mem_wen, mem_dst, wb_wen, wb_dst));
    e_st = ref_stall(ex_is_load, ex_wen, ex_dst, id_src_a, id_src_b, id_is_store);
    chk(st_tag, idex_bubble, e_st);
    chk("R10", pc_we, 1 - e_st);
    chk("R10", ifid_we, 1 - e_st);
  endtask

  task automatic idle();
    {id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst} = '0;
    {id_is_store, ex_wen, ex_is_load, mem_wen, wb_wen} = '0;
  endtask

  function automatic logic [4:0] pick();
    case ($urandom % 5)
      0: return 5'd0;
      1: return 5'd1;
      2: return 5'd2;
      3: return 5'd3;
      default: return 5'd31;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    compare_all("R4", "R7");  // idle state

    // R1 memory-stage bypass on A
    @(negedge clk); idle(); ex_src_a = 5; mem_wen = 1; mem_dst = 5; #1;
    chk("R1", fwd_a, 2); chk("R5", fwd_b, 0);
    // R2 write-back bypass on B only
    @(negedge clk); idle(); ex_src_b = 7; wb_wen = 1; wb_dst = 7; ex_src_a = 6; #1;
    chk("R2", fwd_b, 1); chk("R5", fwd_a, 0);
    // R3 double match prefers younger
    @(negedge clk); idle(); ex_src_a = 9; mem_wen = 1; mem_dst = 9; wb_wen = 1; wb_dst = 9; #1;
    chk("R3", fwd_a, 2);
    // R4 zero register and disabled write never match
    @(negedge clk); idle(); ex_src_a = 31; mem_wen = 1; mem_dst = 31; wb_wen = 0; wb_dst = 31; #1;
    chk("R4", fwd_a, 0);
    // R5 A from memory stage, B from write-back at once
    @(negedge clk); idle(); ex_src_a = 4; ex_src_b = 8; mem_wen = 1; mem_dst = 4; wb_wen = 1; wb_dst = 8; #1;
    chk("R5", fwd_a, 2); chk("R5", fwd_b, 1);
    // R6 load-use on second source of ALU op
    @(negedge clk); idle(); ex_is_load = 1; ex_wen = 1; ex_dst = 3; id_src_b = 3; id_src_a = 1; #1;
    chk("R6", idex_bubble, 1); chk("R6", pc_we, 0); chk("R6", ifid_we, 0);
    // R7 non-load producer with a match does not stall
    @(negedge clk); idle(); ex_wen = 1; ex_dst = 3; id_src_a = 3; #1;
    chk("R7", idex_bubble, 0); chk("R7", pc_we, 1);
    // R8 store data-only match: no stall
    @(negedge clk); idle(); ex_is_load = 1; ex_wen = 1; ex_dst = 6; id_is_store = 1; id_src_a = 2; id_src_b = 6; #1;
    chk("R8", idex_bubble, 0); chk("R8", ifid_we, 1);
    // R8 store base match: stall
    @(negedge clk); id_src_a = 6; id_src_b = 2; #1;
    chk("R8", idex_bubble, 1);
    // R9 load to register 31
    @(negedge clk); idle(); ex_is_load = 1; ex_wen = 1; ex_dst = 31; id_src_a = 31; id_src_b = 31; #1;
    chk("R9", idex_bubble, 0); chk("R9", pc_we, 1);

    // R11 load then dependent: stall, bubble, write-back bypass
    @(negedge clk); idle(); ex_is_load = 1; ex_wen = 1; ex_dst = 12; id_src_a = 12; #1;
    chk("R11", idex_bubble, 1);
    @(negedge clk); idle(); mem_wen = 1; mem_dst = 12; id_src_a = 12; #1;
    chk("R11", idex_bubble, 0);
    @(negedge clk); idle(); wb_wen = 1; wb_dst = 12; ex_src_a = 12; #1;
    chk("R11", fwd_a, 1);

    // random cycles; R5 independence covered by distinct A/B sources
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      id_src_a = pick(); id_src_b = pick(); ex_src_a = pick(); ex_src_b = pick();
      ex_dst = pick(); mem_dst = pick(); wb_dst = pick();
      id_is_store = $urandom % 2; ex_wen = $urandom % 2; ex_is_load = $urandom % 2;
      mem_wen = $urandom % 2; wb_wen = $urandom % 2;
      #1;
      begin
        string st;
        if (ex_is_load && ex_dst == 31) st = "R9";
        else if (id_is_store) st = "R8";
        else if (ref_stall(ex_is_load, ex_wen, ex_dst, id_src_a, id_src_b, 0) != 0) st = "R6";
        else st = "R7";
        compare_all(sel_tag(ex_src_a), st);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule